// File: doc/BRIEF.md
# Oversampling Averaging Conversion Controller

This block runs one multi-channel, simultaneous-sampling conversion with an optional oversampling ratio N. A rising edge on either of two convert-start inputs starts the first sample round, which covers all channels. The controller then times the remaining N−1 rounds itself, one every `ROUND_CYCLES` clocks. The analog front end is modelled as a request/valid port. Each request pulse asks for one round, and a later valid cycle returns one signed 16-bit word per channel. Each channel keeps a running sum of its N samples. The sum is divided by N with an arithmetic right shift, so the averaged result keeps 16-bit resolution.

`busy` is high for the whole multi-round conversion. When `busy` falls, two things happen on the same clock edge. The output data registers load the new averages, and the 3-bit ratio code is captured. That captured code sets the ratio of the next conversion, not of the one just finished. A host may therefore read `result` while `busy` is high, and it sees the previous conversion's values.

Three sticky flags report misuse:
- `overrun`: a convert-start edge arrived while the block was busy.
- `invalid_cfg`: the reserved ratio code was captured.
- `cnvst_mismatch`: the two convert-start inputs differed while oversampling was active.

Top module: `os_avg_ctrl`

## Requirements
- R1: After reset, `busy`, `smp_req`, `result` and all three flags are 0. The ratio in force is 1, so the first conversion takes exactly one round.
- R2: The two convert-start inputs are ORed. A rising edge of that OR while `busy` is low raises `busy` and `smp_req` on the next clock.
- R3: A conversion with ratio N issues exactly N single-cycle `smp_req` pulses, all while `busy` is high. Consecutive pulses are `ROUND_CYCLES` clocks apart when the sample latency is below that.
- R4: Channel i of `result` occupies bits [16i+15:16i]. It equals the sum of that channel's N signed samples shifted arithmetically right by log2(N), which rounds toward minus infinity.
- R5: The ratio code is captured on the clock where `busy` falls and applies to the following conversion. Codes 000, 001, 010, 011, 100, 101 and 110 give N = 1, 2, 4, 8, 16, 32 and 64.
- R6: Code 111 is treated as N = 1 and sets `invalid_cfg`, which stays set until reset.
- R7: `result` changes only on the clock where `busy` falls. While `busy` is high it holds the previous conversion's values.
- R8: A rising convert-start edge while `busy` is high starts nothing, adds no request, and sets `overrun`, which stays set until reset.
- R9: `cnvst_mismatch` is set if the two convert-start inputs differ in any cycle where the ratio in force is above 1. It stays set until reset, and it is not set when the ratio is 1.
- R10: `busy` stays high from the clock after the start edge until the clock after the last round's valid cycle. For a sample latency of L clocks from request to valid, that is (N−1)·`ROUND_CYCLES` + L + 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnvst_a | input | 1 | Convert-start, channel group A |
| cnvst_b | input | 1 | Convert-start, channel group B |
| ratio_code | input | 3 | Oversampling ratio code, captured when busy falls |
| smp_req | output | 1 | One-cycle request for a sample round |
| smp_valid | input | 1 | Sample round data valid |
| smp_data | input | NUM_CH*DATA_W | Packed signed samples, channel i at bits [16i+15:16i] |
| busy | output | 1 | Conversion in progress |
| result | output | NUM_CH*DATA_W | Packed averaged results, same lane layout |
| overrun | output | 1 | Sticky: start edge seen while busy |
| invalid_cfg | output | 1 | Sticky: reserved ratio code captured |
| cnvst_mismatch | output | 1 | Sticky: convert-start inputs differed while oversampling |

## Verification
Some properties are checked on every cycle:
- Start edges raise `busy` together with a request, and a start edge while busy sets `overrun`.
- Requests are single pulses that occur only inside `busy`.
- `result` can change only at the falling edge of `busy`.
- All three flags are sticky.

Other behaviour is shown only by the bench scenarios:
- The arithmetic of the averages, including full-scale positive and negative lanes.
- Capture of the ratio code one conversion late, and the handling of the reserved code.
- The exact number and spacing of rounds for ratios 1, 2, 4, 8 and 64, and the exact length of `busy`.
- That a start edge while busy adds no round.

// File: rtl/os_avg_pkg.sv
package os_avg_pkg;
    // Largest shift: ratio 64
    localparam int MAX_SHIFT = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PACE,
        ST_DONE
    } seq_state_t;

    // Ratio code to shift amount; the reserved code falls back to ratio 1
    function automatic logic [2:0] code_to_shift(input logic [2:0] code);
        return (code == 3'b111) ? 3'd0 : code;
    endfunction
endpackage

// File: rtl/os_trig.sv
module os_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic cnvst_a,
    input  logic cnvst_b,
    output logic start_rise,
    output logic level_diff
);
    logic merged;
    logic prev_d, prev_q;

    always_comb begin
        merged     = cnvst_a | cnvst_b;
        prev_d     = merged;
        start_rise = merged & ~prev_q;
        level_diff = cnvst_a ^ cnvst_b;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/os_seq.sv
module os_seq #(
    parameter int ROUND_CYCLES = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_rise,
    input  logic       level_diff,
    input  logic       smp_valid,
    input  logic [2:0] ratio_code,
    output logic       busy,
    output logic       smp_req,
    output logic       acc_en,
    output logic       acc_first,
    output logic       load,
    output logic [2:0] shift_cur,
    output logic       overrun,
    output logic       invalid_cfg,
    output logic       cnvst_mismatch
);
    import os_avg_pkg::*;

    localparam int TMR_W = $clog2(ROUND_CYCLES + 1);
    localparam int RND_W = MAX_SHIFT;
    localparam logic [TMR_W-1:0] TMR_MAX  = {TMR_W{1'b1}};
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(ROUND_CYCLES - 1);

    typedef struct packed {
        seq_state_t       state;
        logic             busy;
        logic             req;
        logic [TMR_W-1:0] timer;
        logic [RND_W-1:0] rnd;
        logic [2:0]       shift;
        logic             ovr;
        logic             inv;
        logic             mis;
    } seq_regs_t;

    seq_regs_t        q, d;
    logic [RND_W:0]   n_full;
    logic [RND_W-1:0] last_rnd;

    always_comb begin
        n_full   = (RND_W + 1)'(1) << q.shift;
        last_rnd = RND_W'(n_full - 1'b1);

        d     = q;
        d.req = 1'b0;

        if (start_rise && q.busy)          d.ovr = 1'b1;
        if ((q.shift != 3'd0) && level_diff) d.mis = 1'b1;

        case (q.state)
            ST_IDLE: begin
                if (start_rise) begin
                    d.state = ST_WAIT;
                    d.busy  = 1'b1;
                    d.req   = 1'b1;
                    d.timer = '0;
                    d.rnd   = '0;
                end
            end
            ST_WAIT: begin
                if (q.timer != TMR_MAX) d.timer = q.timer + 1'b1;
                if (smp_valid) begin
                    if (q.rnd == last_rnd) begin
                        d.state = ST_DONE;
                    end else begin
                        d.rnd   = q.rnd + 1'b1;
                        d.state = ST_PACE;
                    end
                end
            end
            ST_PACE: begin
                if (q.timer != TMR_MAX) d.timer = q.timer + 1'b1;
                if (q.timer >= TMR_LAST) begin
                    d.req   = 1'b1;
                    d.timer = '0;
                    d.state = ST_WAIT;
                end
            end
            ST_DONE: begin
                d.busy  = 1'b0;
                d.state = ST_IDLE;
                d.shift = code_to_shift(ratio_code);
                if (ratio_code == 3'b111) d.inv = 1'b1;
            end
            default: d.state = ST_IDLE;
        endcase

        busy           = q.busy;
        smp_req        = q.req;
        acc_en         = (q.state == ST_WAIT) && smp_valid;
        acc_first      = (q.rnd == '0);
        load           = (q.state == ST_DONE);
        shift_cur      = q.shift;
        overrun        = q.ovr;
        invalid_cfg    = q.inv;
        cnvst_mismatch = q.mis;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, busy: 1'b0, req: 1'b0, timer: '0,
                   rnd: '0, shift: 3'd0, ovr: 1'b0, inv: 1'b0, mis: 1'b0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/os_lane.sv
module os_lane #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              first,
    input  logic              load,
    input  logic [2:0]        shift,
    input  logic [DATA_W-1:0] sample,
    output logic [DATA_W-1:0] result
);
    logic signed [ACC_W-1:0] acc_d, acc_q, ext, shifted;
    logic [DATA_W-1:0]       res_d, res_q;

    always_comb begin
        ext     = ACC_W'($signed(sample));
        shifted = acc_q >>> shift;
        acc_d   = acc_q;
        if (en) acc_d = first ? ext : (acc_q + ext);
        res_d   = load ? shifted[DATA_W-1:0] : res_q;
        result  = res_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            res_q <= '0;
        end else begin
            acc_q <= acc_d;
            res_q <= res_d;
        end
    end
endmodule

// File: rtl/os_avg_ctrl.sv
module os_avg_ctrl #(
    parameter int NUM_CH       = 6,
    parameter int DATA_W       = 16,
    parameter int ROUND_CYCLES = 250
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cnvst_a,
    input  logic                     cnvst_b,
    input  logic [2:0]               ratio_code,
    output logic                     smp_req,
    input  logic                     smp_valid,
    input  logic [NUM_CH*DATA_W-1:0] smp_data,
    output logic                     busy,
    output logic [NUM_CH*DATA_W-1:0] result,
    output logic                     overrun,
    output logic                     invalid_cfg,
    output logic                     cnvst_mismatch
);
    localparam int ACC_W = DATA_W + os_avg_pkg::MAX_SHIFT;

    logic       start_rise, level_diff;
    logic       acc_en, acc_first, load;
    logic [2:0] shift_cur;

    os_trig u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnvst_a    (cnvst_a),
        .cnvst_b    (cnvst_b),
        .start_rise (start_rise),
        .level_diff (level_diff)
    );

    os_seq #(.ROUND_CYCLES(ROUND_CYCLES)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_rise     (start_rise),
        .level_diff     (level_diff),
        .smp_valid      (smp_valid),
        .ratio_code     (ratio_code),
        .busy           (busy),
        .smp_req        (smp_req),
        .acc_en         (acc_en),
        .acc_first      (acc_first),
        .load           (load),
        .shift_cur      (shift_cur),
        .overrun        (overrun),
        .invalid_cfg    (invalid_cfg),
        .cnvst_mismatch (cnvst_mismatch)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        os_lane #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (acc_en),
            .first  (acc_first),
            .load   (load),
            .shift  (shift_cur),
            .sample (smp_data[ch*DATA_W +: DATA_W]),
            .result (result[ch*DATA_W +: DATA_W])
        );
    end
endmodule

// File: rtl/os_avg_ctrl_chk.sv
module os_avg_ctrl_chk #(
    parameter int NUM_CH = 6,
    parameter int DATA_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cnvst_a,
    input logic                     cnvst_b,
    input logic                     smp_req,
    input logic                     busy,
    input logic [NUM_CH*DATA_W-1:0] result,
    input logic                     overrun,
    input logic                     invalid_cfg,
    input logic                     cnvst_mismatch
);
    logic cnv_prev;
    logic rise;

    always_ff @(posedge clk) begin
        if (!rst_n) cnv_prev <= 1'b0;
        else        cnv_prev <= cnvst_a | cnvst_b;
    end

    assign rise = (cnvst_a | cnvst_b) & ~cnv_prev;

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !busy) |=> (busy && smp_req));

    assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_req |=> !smp_req);

    assert_req_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_req |-> busy);

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(result));

    assert_hold_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(result)));

    assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && busy) |=> overrun);

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    assert_invalid_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_cfg |=> invalid_cfg);

    assert_mismatch_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnvst_mismatch |=> cnvst_mismatch);
endmodule

bind os_avg_ctrl os_avg_ctrl_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cnvst_a        (cnvst_a),
    .cnvst_b        (cnvst_b),
    .smp_req        (smp_req),
    .busy           (busy),
    .result         (result),
    .overrun        (overrun),
    .invalid_cfg    (invalid_cfg),
    .cnvst_mismatch (cnvst_mismatch)
);

// File: tb/os_avg_ctrl_bench.sv
module os_avg_ctrl_bench;
    localparam int NCH = 6;
    localparam int DW  = 16;
    localparam int RC  = 16;
    localparam int LAT = 3;

    typedef logic [NCH*DW-1:0] vec_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cnvst_a, cnvst_b;
    logic [2:0] ratio_code;
    logic       smp_req, smp_valid;
    vec_t       smp_data, result;
    logic       busy, overrun, invalid_cfg, cnvst_mismatch;

    always #10 clk = ~clk;

    os_avg_ctrl #(.NUM_CH(NCH), .DATA_W(DW), .ROUND_CYCLES(RC)) u_os_avg_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cnvst_a        (cnvst_a),
        .cnvst_b        (cnvst_b),
        .ratio_code     (ratio_code),
        .smp_req        (smp_req),
        .smp_valid      (smp_valid),
        .smp_data       (smp_data),
        .busy           (busy),
        .result         (result),
        .overrun        (overrun),
        .invalid_cfg    (invalid_cfg),
        .cnvst_mismatch (cnvst_mismatch)
    );

    int checks = 0;
    int errors = 0;
    int conv_id = 0;
    int rnd = 0;
    int cyc = 0;
    int req_cnt = 0;
    int spacing_err = 0;
    int last_req_cyc = 0;
    int done_cnt = 0;
    int cur_n = 1;
    vec_t last_res = '0;
    vec_t exp_q[$];
    int   expn_q[$];

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sample_val(input int cv, input int r, input int ch);
        if (ch == 0) return 32767;
        if (ch == 1) return -32768;
        return ((cv * 7919 + r * 1237 + ch * 4099) % 65536) - 32768;
    endfunction

    // Front-end model: answers each request LAT clocks later
    initial begin
        smp_valid = 1'b0;
        smp_data  = '0;
        forever begin
            @(negedge clk);
            if (smp_req === 1'b1) begin
                int r;
                r = rnd;
                req_cnt++;
                if (req_cnt > 1 && (cyc - last_req_cyc) != RC) spacing_err++;
                last_req_cyc = cyc;
                rnd++;
                repeat (LAT) @(negedge clk);
                smp_valid = 1'b1;
                for (int ch = 0; ch < NCH; ch++)
                    smp_data[ch*DW +: DW] = DW'(sample_val(conv_id, r, ch));
                @(negedge clk);
                smp_valid = 1'b0;
            end
        end
    end

    // Monitor: scores each completed conversion at busy falling
    initial begin
        logic busy_prev;
        int   blen;
        busy_prev = 1'b0;
        blen = 0;
        forever begin
            @(negedge clk);
            if (busy === 1'b1) blen++;
            if (busy_prev && busy === 1'b0) begin
                vec_t e;
                int   n;
                e = exp_q.pop_front();
                n = expn_q.pop_front();
                for (int ch = 0; ch < NCH; ch++)
                    chk(result[ch*DW +: DW] === e[ch*DW +: DW], "R4", $sformatf("lane %0d", ch),
                        longint'($signed(result[ch*DW +: DW])), longint'($signed(e[ch*DW +: DW])));
                chk(req_cnt == n, "R3", "request count", req_cnt, n);
                chk(spacing_err == 0, "R3", "request spacing errors", spacing_err, 0);
                chk(blen == (n - 1) * RC + LAT + 2, "R10", "busy length", blen, (n - 1) * RC + LAT + 2);
                blen = 0;
                done_cnt++;
            end
            busy_prev = busy;
        end
    end

    // Driver: pushes the expected averages, then triggers one conversion
    task automatic run_conv(input logic [2:0] code, input bit use_a, input bit use_b, input bit glitch);
        vec_t e;
        int   n, target;
        n = cur_n;
        for (int ch = 0; ch < NCH; ch++) begin
            int sum;
            sum = 0;
            for (int r = 0; r < n; r++) sum += sample_val(conv_id, r, ch);
            e[ch*DW +: DW] = DW'(sum >>> $clog2(n));
        end
        exp_q.push_back(e);
        expn_q.push_back(n);
        ratio_code = code;
        rnd = 0;
        req_cnt = 0;
        spacing_err = 0;
        target = done_cnt + 1;
        @(negedge clk);
        cnvst_a = use_a;
        cnvst_b = use_b;
        repeat (2) @(negedge clk);
        cnvst_a = 1'b0;
        cnvst_b = 1'b0;
        chk(busy === 1'b1, "R2", "busy after start edge", longint'(busy), 1);
        chk(result === last_res, "R7", "result during busy lane 2",
            longint'($signed(result[2*DW +: DW])), longint'($signed(last_res[2*DW +: DW])));
        if (glitch) begin
            repeat (5) @(negedge clk);
            cnvst_a = 1'b1;
            @(negedge clk);
            cnvst_a = 1'b0;
        end
        while (done_cnt < target) @(negedge clk);
        last_res = e;
        cur_n = (code == 3'b111) ? 1 : (1 << code);
        conv_id++;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cnvst_a = 1'b0;
        cnvst_b = 1'b0;
        ratio_code = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "R1", "busy at reset", longint'(busy), 0);
        chk(smp_req === 1'b0, "R1", "request at reset", longint'(smp_req), 0);
        chk(result === '0, "R1", "result at reset", longint'(result[DW-1:0]), 0);
        chk({overrun, invalid_cfg, cnvst_mismatch} === 3'b000, "R1", "flags at reset",
            longint'({overrun, invalid_cfg, cnvst_mismatch}), 0);

        // R1/R2: first conversion at ratio 1, started from group B only
        run_conv(3'b010, 1'b0, 1'b1, 1'b0);
        // R5: code 010 captured above gives 4 rounds now
        run_conv(3'b011, 1'b1, 1'b1, 1'b0);
        // R5: 8 rounds
        run_conv(3'b000, 1'b1, 1'b1, 1'b0);
        // R9: ratio 1 with only group A, no mismatch
        run_conv(3'b110, 1'b1, 1'b0, 1'b0);
        chk(cnvst_mismatch === 1'b0, "R9", "mismatch at ratio 1", longint'(cnvst_mismatch), 0);
        chk(overrun === 1'b0, "R8", "overrun before any early edge", longint'(overrun), 0);
        chk(invalid_cfg === 1'b0, "R6", "invalid before reserved code", longint'(invalid_cfg), 0);
        // 64 rounds, group A only, extra edge while busy, reserved code captured
        run_conv(3'b111, 1'b1, 1'b0, 1'b1);
        chk(cnvst_mismatch === 1'b1, "R9", "mismatch while oversampling", longint'(cnvst_mismatch), 1);
        chk(overrun === 1'b1, "R8", "overrun after early edge", longint'(overrun), 1);
        chk(invalid_cfg === 1'b1, "R6", "invalid after reserved code", longint'(invalid_cfg), 1);
        chk(busy === 1'b0, "R8", "no extra conversion", longint'(busy), 0);
        // R6: reserved code gives one round
        run_conv(3'b001, 1'b1, 1'b1, 1'b0);
        // R5: code 001 gives 2 rounds
        run_conv(3'b000, 1'b1, 1'b1, 1'b0);
        chk(invalid_cfg === 1'b1, "R6", "invalid stays set", longint'(invalid_cfg), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule